// File: doc/BRIEF.md
# Timing-Error Detecting Output Register

This block is a bank of output registers for the wide product of a multiplier. It is meant for a datapath whose clock period is shorter than the worst-case logic delay. Each bit is captured twice. A main flop samples the data on the rising edge of the main clock. A shadow flop samples the same data on the rising edge of a second clock, which is supplied from outside and lags the main clock by a fraction of a period. When the two copies of any bit disagree, the capture at the main edge was too early. The block then reports a timing error, and on the next main edge it loads the shadow copy into the main register. The correct word therefore appears one cycle late, and the operation is not run again.

Words enter on a valid/ready pair and leave on a valid flag. The upstream side may offer a word at any edge. A word is taken at an edge where both `in_valid` and `in_ready` are high. `in_ready` goes low for exactly one cycle while a failed capture is being repaired, and the offered word must then stay in place until it is taken. The output side cannot stall the block. `out_valid` marks a cycle in which `out_data` holds a trusted word, and the consumer must take it in that cycle.

The input word has a hold rule. After the main edge that takes a word, `in_data` must keep that word, or its late-settling final value, until the delayed edge has passed. The single-bit `err` pulse is the event feed for an aging counter placed outside this block.

Top module: `razor_reg_bank`

## Requirements
- R1: While `rst_n` is low, `out_data` is zero, `out_valid` and `err` are low and `in_ready` is high. This holds for both clocks' storage.
- R2: A word taken at an edge whose value is unchanged at the following delayed edge appears on `out_data` in the cycle after that edge, with `out_valid` high, `err` low and `in_ready` high.
- R3: If a taken word's value at the delayed edge differs from its value at the main edge, then after the next main edge `out_data` equals the value seen at the delayed edge and `err` is high for that cycle.
- R4: During the cycle in which a mismatch is pending, `in_ready` is low, so an offered word is not taken at the next edge. It is taken one edge later, a penalty of one cycle.
- R5: `out_valid` is low in the cycle holding a mismatched capture and high in the following repair cycle.
- R6: A difference in any single bit position, from bit 0 up to the top bit, is detected and repaired.
- R7: At an edge with `in_valid` low, nothing is captured, whatever `in_data` does. `out_data` keeps its value, and `out_valid` and `err` are low in the next cycle.
- R8: `err` is never high in two consecutive cycles. Each failed capture gives one single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock, rising edge |
| clk_dly | input | 1 | Delayed copy of the main clock, clocks the shadow flops |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Upstream offers a word |
| in_ready | output | 1 | Low for one cycle while a failed capture is repaired |
| in_data | input | 2*MULT_W | Product word from the multiplier |
| out_valid | output | 1 | `out_data` holds a trusted word this cycle |
| out_data | output | 2*MULT_W | Registered word |
| err | output | 1 | One-cycle timing-error pulse for the aging counter |

## Verification
The repair of a failed capture and the offer of the next upstream word fall in the same cycle. The bench provokes this by presenting a wrong word before a main edge and switching to the correct word between that edge and the delayed edge. In that same cycle it already offers a fresh word. It then judges that the repair edge loads the late value and raises `err`, and that the fresh word is refused at that edge and taken at the next one. Idle cycles with changing input data are mixed in to confirm that shadow samples with no word behind them never raise an error.

// File: rtl/razor_pkg.sv
`timescale 1ns/100ps
package razor_pkg;
  // width of one multiplier operand; the stored product is twice this
  parameter int unsigned RZ_MULT_W = 4;

  // outcome of comparing the two captures of one word
  typedef enum logic [1:0] {
    CAP_IDLE  = 2'b00,
    CAP_CLEAN = 2'b01,
    CAP_FAIL  = 2'b10
  } cap_state_e;
endpackage

// File: rtl/razor_bit.sv
`timescale 1ns/100ps
// One stored bit: main flop on clk, shadow flop on clk_dly, mismatch flag.
module razor_bit (
  input  logic clk,
  input  logic clk_dly,
  input  logic rst_n,
  input  logic cap_en,
  input  logic restore,
  input  logic d,
  output logic q,
  output logic mism
);
  logic shadow_q;

  // main capture; a repair has priority and uses the shadow copy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= 1'b0;
    else if (restore) q <= shadow_q;
    else if (cap_en)  q <= d;
  end

  // late sample of the same net
  always_ff @(posedge clk_dly or negedge rst_n) begin
    if (!rst_n) shadow_q <= 1'b0;
    else        shadow_q <= d;
  end

  assign mism = q ^ shadow_q;
endmodule

// File: rtl/razor_ctrl.sv
`timescale 1ns/100ps
// Shared control: combines per-bit mismatches, handles stall and repair.
module razor_ctrl
  import razor_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] mism,
  output logic         in_ready,
  output logic         cap_en,
  output logic         restore,
  output logic         out_valid,
  output logic         err
);
  logic       armed_q;   // a word was taken at the last edge
  logic       fix_q;     // last edge repaired a word
  logic       any_mism;
  cap_state_e state;

  assign any_mism = |mism;

  always_comb begin
    if (!armed_q)      state = CAP_IDLE;
    else if (any_mism) state = CAP_FAIL;
    else               state = CAP_CLEAN;
  end

  assign restore   = (state == CAP_FAIL);
  assign in_ready  = !restore;
  assign cap_en    = in_valid && in_ready;
  assign out_valid = (state == CAP_CLEAN) || fix_q;
  assign err       = fix_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      fix_q   <= 1'b0;
    end else begin
      armed_q <= cap_en;
      fix_q   <= restore;
    end
  end
endmodule

// File: rtl/razor_reg_bank.sv
`timescale 1ns/100ps
// Output register bank with per-bit late-sample checking and repair.
module razor_reg_bank
  import razor_pkg::*;
#(
  parameter int unsigned MULT_W = RZ_MULT_W,
  localparam int unsigned DATA_W = 2 * MULT_W
) (
  input  logic              clk,
  input  logic              clk_dly,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              err
);
  logic [DATA_W-1:0] mism;
  logic              cap_en;
  logic              restore;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    razor_bit u_bit (
      .clk     (clk),
      .clk_dly (clk_dly),
      .rst_n   (rst_n),
      .cap_en  (cap_en),
      .restore (restore),
      .d       (in_data[b]),
      .q       (out_data[b]),
      .mism    (mism[b])
    );
  end

  razor_ctrl #(.W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mism      (mism),
    .in_ready  (in_ready),
    .cap_en    (cap_en),
    .restore   (restore),
    .out_valid (out_valid),
    .err       (err)
  );
endmodule

// File: rtl/razor_reg_bank_chk.sv
`timescale 1ns/100ps
module razor_reg_bank_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_data,
  input logic         out_valid,
  input logic [W-1:0] out_data,
  input logic         err
);
  always_comb begin
    if (!rst_n) begin
      a_reset_r1: assert (!err && !out_valid && in_ready && out_data == '0);
    end
  end

  p_accept_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid == in_ready) && !err);

  p_stall_then_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> err && in_ready);

  p_repair_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> out_valid);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> ($stable(out_data) && !out_valid && !err));

  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  logic unused_in;
  assign unused_in = ^in_data;
endmodule

bind razor_reg_bank razor_reg_bank_chk #(.W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data),
  .err       (err)
);

// File: tb/test_razor_reg_bank.sv
`timescale 1ns/100ps
module test_razor_reg_bank;
  localparam int MW = 4;
  localparam int W  = 2 * MW;

  logic         clk = 1'b0, clk_dly = 1'b0, rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_ready, out_valid, err;
  logic [W-1:0] out_data;

  int errors = 0, checks = 0;
  logic [W-1:0] e_data = '0, fail_good = '0;
  logic e_valid = 1'b0, e_err = 1'b0, e_ready = 1'b1;
  bit   phase_r6 = 1'b0;

  razor_reg_bank #(.MULT_W(MW)) i_razor_reg_bank (
    .clk(clk), .clk_dly(clk_dly), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .err(err)
  );

  always #2.5 clk = ~clk;              // 200 MHz
  initial begin
    #1.5;
    forever #2.5 clk_dly = ~clk_dly;   // lags clk by 1.5 ns
  end

  function automatic logic needs_fix(logic late, logic [W-1:0] bad, logic [W-1:0] good);
    return late && (bad != good);
  endfunction

  function automatic logic [W-1:0] main_word(logic late, logic [W-1:0] bad, logic [W-1:0] good);
    return late ? bad : good;
  endfunction

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // offer one word (or an idle cycle) and repeat until it is taken
  task automatic offer(input logic v, input logic [W-1:0] good,
                       input logic late, input logic [W-1:0] bad);
    logic acc, prev_err;
    bit   done;
    string dtag, etag;
    done = 1'b0;
    while (!done) begin
      in_valid = v;
      in_data  = (v && late) ? bad : good;
      acc      = v && e_ready;
      @(posedge clk);
      prev_err = e_err;
      if (!e_ready) begin
        e_data = fail_good; e_err = 1'b1; e_valid = 1'b1; e_ready = 1'b1; dtag = "R3";
      end else if (acc) begin
        e_err = 1'b0; dtag = "R2";
        if (needs_fix(late, bad, good)) begin
          e_data = main_word(late, bad, good); e_valid = 1'b0; e_ready = 1'b0; fail_good = good;
        end else begin
          e_data = good; e_valid = 1'b1; e_ready = 1'b1;
        end
      end else begin
        e_valid = 1'b0; e_err = 1'b0; e_ready = 1'b1; dtag = "R7";
      end
      #0.5;
      if (acc && late) in_data = good;   // settles between the two edges
      #3;
      etag = prev_err ? "R8" : (phase_r6 ? "R6" : "R3");
      chk(dtag,  "out_data",  out_data,     e_data);
      chk("R5",  "out_valid", W'(out_valid), W'(e_valid));
      chk(etag,  "err",       W'(err),       W'(e_err));
      chk("R4",  "in_ready",  W'(in_ready),  W'(e_ready));
      #0.5;
      done = !v || acc;
    end
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] g, b;
    logic v, l;
    void'($urandom(32'd2024));
    in_data = 8'h3C;
    #11;
    // R1: reset state
    chk("R1", "out_data",  out_data,      '0);
    chk("R1", "out_valid", W'(out_valid), '0);
    chk("R1", "err",       W'(err),       '0);
    chk("R1", "in_ready",  W'(in_ready),  W'(1'b1));
    @(posedge clk); #4;
    rst_n = 1'b1;

    // R2: on-time words
    offer(1'b1, 8'hA5, 1'b0, '0);
    offer(1'b1, 8'h00, 1'b0, '0);
    offer(1'b1, 8'hFF, 1'b0, '0);
    // R7: idle cycles with churning data
    offer(1'b0, 8'h5A, 1'b0, '0);
    offer(1'b0, 8'hC3, 1'b1, 8'h11);
    // R3/R4: late word, next word offered during the failing cycle
    offer(1'b1, 8'h96, 1'b1, 8'h69);
    offer(1'b1, 8'h42, 1'b0, '0);
    // late but unchanged value: no error
    offer(1'b1, 8'h77, 1'b1, 8'h77);
    // R6: single-bit difference at every position
    phase_r6 = 1'b1;
    for (int k = 0; k < W; k++) begin
      offer(1'b1, 8'hB4, 1'b1, 8'hB4 ^ W'(1 << k));
      offer(1'b0, W'($urandom), 1'b0, '0);
    end
    phase_r6 = 1'b0;
    // back-to-back failures
    offer(1'b1, 8'h0F, 1'b1, 8'hF0);
    offer(1'b1, 8'h1E, 1'b1, 8'hE1);

    // constrained random
    for (int n = 0; n < 2000; n++) begin
      v = ($urandom % 4) != 0;
      g = W'($urandom);
      l = ($urandom % 3) == 0;
      b = ($urandom % 2) ? (g ^ W'(1 << ($urandom % W))) : W'($urandom);
      offer(v, g, l, b);
    end
    offer(1'b0, '0, 1'b0, '0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule